// File: doc/BRIEF.md
# Display DMA Channel Control Unit

This block holds the complete register state of one display DMA channel and sequences it between software and an address walker. Software reaches it through a 16-bit register port with a combinational read path. Transfer parameters are first written into a programmed (shadow) set. They are then moved into an active set that drives the walker: this happens at once if the channel is idle, or at the next block boundary if it is running.

The block starts the walker with a one-cycle start pulse. The walker reports the end of each block with a one-cycle completion pulse. On each completion the block either reloads the active set from the shadow set and restarts, when auto-init and repeat are both selected, or stops the channel. A sticky completion flag is cleared by writing one to it. The flag, gated by an enable bit, forms the interrupt line.

Moving data and computing addresses are left to the walker. This unit only supplies its parameters and tells it when to run.

Top module: `dispchan_ctl`

Register map (word addresses): 0 channel control, 1 parameters, 2 logical-channel control, 3 display control, 4/5 start address upper/lower half, 6/7 end address upper/lower half, 8/9 frame index upper/lower half, 10 element count, 11 frame count, 12 element index. Addresses 13 to 15 read as zero.

## Requirements
- R1: After reset, channel control reads 0x5440, parameters read 0x9102, logical-channel control reads 0x0004 and display control reads 0x0000. The external request gate (display control bit 8) is 0, and running, start and irq are all 0.
- R2: Each 32-bit value (start address, end address, frame index) is written as an upper half at the even address and a lower half at the odd address. Every shadow register reads back the last value written to it.
- R3: Writing channel control bit 11 = 1 marks the shadow set complete. While idle, the shadow set is copied to the active outputs on the next clock edge and bit 11 then reads 0. While running, the active outputs keep their old values until the next completion pulse, when the copy happens.
- R4: When channel control bit 7 is 1 and the channel is idle, running goes to 1 on the next edge, and start pulses high for exactly that one cycle.
- R5: When bits 9:8 of channel control are not both 1, a completion pulse while running stops the channel on the next edge and clears bit 7. No start pulse follows.
- R6: When bits 9:8 are both 1 and bit 7 is set, a completion pulse reloads the active set from the shadow set and pulses start on the next edge. Running stays 1.
- R7: Display control bit 3 is set by a completion pulse while running. It is cleared by writing 1 to it; writing 0 leaves it alone. If a set and a clear fall in the same cycle, the set wins. A completion pulse while idle is ignored.
- R8: irq equals display control bit 3 AND display control bit 1.
- R9: Writing channel control with bit 7 = 0 while running makes running 0 from the next edge on.
- R10: A write to channel control that takes bit 0 from 1 to 0 releases the channel. On the next edge running is 0 and bit 7 is 0, whatever bit 7 of the written value is.
- R11: On each copy, the active data-type output takes parameters bits 1:0. The double-index output is 1 exactly when channel control bits 13:12 equal 3. The source-port output follows display control bits 7:6 (0 selects external SDRAM), and the external request gate output follows bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| blk_done | input | 1 | Block-complete pulse from the walker |
| start | output | 1 | One-cycle start pulse to the walker |
| running | output | 1 | Channel running status |
| irq | output | 1 | Completion interrupt |
| act_top | output | 32 | Active start address |
| act_bot | output | 32 | Active end address |
| act_fidx | output | 32 | Active frame index |
| act_ecnt | output | 16 | Active element count |
| act_fcnt | output | 16 | Active frame count |
| act_eidx | output | 16 | Active element index |
| act_dtype | output | 2 | Active data-type code |
| act_dbl_idx | output | 1 | Active double-indexed addressing |
| src_port | output | 2 | Source port select |
| ext_req_en | output | 1 | External controller request gate |

## Verification
Two pairs of events can land in the same cycle. A block completion can coincide with a software write of one to the completion flag. A block completion in repeat mode can coincide with a pending end-of-programming reload. The bench provokes both by raising the completion pulse in the very cycle that carries the register write. It then judges the outcome twice: against a behavioural per-cycle model, and by reading back that the flag stayed set and that the new shadow values reached the active outputs together with a fresh start pulse.

// File: rtl/dispchan_ctl.sv
module dispchan_ctl #(
  parameter int          AW      = 4,
  parameter logic [15:0] CC_RST  = 16'h5440,
  parameter logic [15:0] PAR_RST = 16'h9102,
  parameter logic [15:0] LCH_RST = 16'h0004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic          blk_done,
  output logic          start,
  output logic          running,
  output logic          irq,
  output logic [31:0]   act_top,
  output logic [31:0]   act_bot,
  output logic [31:0]   act_fidx,
  output logic [15:0]   act_ecnt,
  output logic [15:0]   act_fcnt,
  output logic [15:0]   act_eidx,
  output logic [1:0]    act_dtype,
  output logic          act_dbl_idx,
  output logic [1:0]    src_port,
  output logic          ext_req_en
);
  localparam logic [AW-1:0] A_CC  = AW'(0);
  localparam logic [AW-1:0] A_PAR = AW'(1);
  localparam logic [AW-1:0] A_LCH = AW'(2);
  localparam logic [AW-1:0] A_DC  = AW'(3);
  localparam logic [AW-1:0] A_TPH = AW'(4);
  localparam logic [AW-1:0] A_TPL = AW'(5);
  localparam logic [AW-1:0] A_BTH = AW'(6);
  localparam logic [AW-1:0] A_BTL = AW'(7);
  localparam logic [AW-1:0] A_FIH = AW'(8);
  localparam logic [AW-1:0] A_FIL = AW'(9);
  localparam logic [AW-1:0] A_EC  = AW'(10);
  localparam logic [AW-1:0] A_FC  = AW'(11);
  localparam logic [AW-1:0] A_EI  = AW'(12);

  logic [15:0] cc, par, lch, dc;
  logic [15:0] top_h, top_l, bot_h, bot_l, fi_h, fi_l, ecnt, fcnt, eidx;
  logic [15:0] cc_nx, dc_nx;

  wire wr_cc = wr_en && (addr == A_CC);
  wire wr_dc = wr_en && (addr == A_DC);
  wire rel   = wr_cc && cc[0] && !wdata[0];
  wire evt   = blk_done && running;
  wire rpt   = evt && (cc[9:8] == 2'b11) && cc[7];
  wire halt  = evt && !rpt;
  wire copy  = rpt || (cc[11] && (!running || evt));

  always_comb begin
    cc_nx = wr_cc ? wdata : cc;
    if (copy && !(wr_cc && wdata[11])) cc_nx[11] = 1'b0;
    if (halt || rel) cc_nx[7] = 1'b0;
    dc_nx = wr_dc ? {wdata[15:4], dc[3], wdata[2:0]} : dc;
    dc_nx[3] = (dc[3] && !(wr_dc && wdata[3])) || evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc <= CC_RST; par <= PAR_RST; lch <= LCH_RST; dc <= '0;
      top_h <= '0; top_l <= '0; bot_h <= '0; bot_l <= '0;
      fi_h <= '0; fi_l <= '0; ecnt <= '0; fcnt <= '0; eidx <= '0;
    end else begin
      cc <= cc_nx;
      dc <= dc_nx;
      if (wr_en) begin
        case (addr)
          A_PAR: par   <= wdata;
          A_LCH: lch   <= wdata;
          A_TPH: top_h <= wdata;
          A_TPL: top_l <= wdata;
          A_BTH: bot_h <= wdata;
          A_BTL: bot_l <= wdata;
          A_FIH: fi_h  <= wdata;
          A_FIL: fi_l  <= wdata;
          A_EC:  ecnt  <= wdata;
          A_FC:  fcnt  <= wdata;
          A_EI:  eidx  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_top <= '0; act_bot <= '0; act_fidx <= '0;
      act_ecnt <= '0; act_fcnt <= '0; act_eidx <= '0;
      act_dtype <= '0; act_dbl_idx <= 1'b0;
    end else if (copy) begin
      act_top     <= {top_h, top_l};
      act_bot     <= {bot_h, bot_l};
      act_fidx    <= {fi_h, fi_l};
      act_ecnt    <= ecnt;
      act_fcnt    <= fcnt;
      act_eidx    <= eidx;
      act_dtype   <= par[1:0];
      act_dbl_idx <= (cc[13:12] == 2'b11);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (rel) running <= 1'b0;
      else if (!running) begin
        if (cc[7]) begin
          running <= 1'b1;
          start   <= 1'b1;
        end
      end else if (rpt) start <= 1'b1;
      else if (halt || !cc[7]) running <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CC:  rdata = cc;
      A_PAR: rdata = par;
      A_LCH: rdata = lch;
      A_DC:  rdata = dc;
      A_TPH: rdata = top_h;
      A_TPL: rdata = top_l;
      A_BTH: rdata = bot_h;
      A_BTL: rdata = bot_l;
      A_FIH: rdata = fi_h;
      A_FIL: rdata = fi_l;
      A_EC:  rdata = ecnt;
      A_FC:  rdata = fcnt;
      A_EI:  rdata = eidx;
      default: rdata = '0;
    endcase
  end

  assign irq        = dc[3] & dc[1];
  assign src_port   = dc[7:6];
  assign ext_req_en = dc[8];

  assert_idle_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cc[11] && !running && !(wr_cc && wdata[11])) |=> !cc[11]);
  assert_start_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> running);
  assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cc[9:8] != 2'b11) |=> (!running && !cc[7] && !start));
  assert_repeat_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cc[9:8] == 2'b11 && cc[7] && !rel) |=> (start && running));
  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> dc[3]);
  assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (!running && !cc[7]));
endmodule

// File: tb/test_dispchan_ctl.sv
module test_dispchan_ctl;
  logic clk = 0, rst_n = 0, wr_en = 0, blk_done = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic start, running, irq, act_dbl_idx, ext_req_en;
  logic [31:0] act_top, act_bot, act_fidx;
  logic [15:0] act_ecnt, act_fcnt, act_eidx;
  logic [1:0] act_dtype, src_port;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dispchan_ctl i_dispchan_ctl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .blk_done(blk_done), .start(start), .running(running),
    .irq(irq), .act_top(act_top), .act_bot(act_bot), .act_fidx(act_fidx),
    .act_ecnt(act_ecnt), .act_fcnt(act_fcnt), .act_eidx(act_eidx), .act_dtype(act_dtype),
    .act_dbl_idx(act_dbl_idx), .src_port(src_port), .ext_req_en(ext_req_en));

  // behavioural reference
  logic [15:0] mr [0:15];
  logic [31:0] mt, mb, mf;
  logic [15:0] me, mfc, mei;
  logic [1:0] mdt;
  logic mdb, mrun, mstart;
  logic ev, rp, rl, cp, old_st;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mr[i] = 16'h0;
      mr[0] = 16'h5440; mr[1] = 16'h9102; mr[2] = 16'h0004;
      mt = 0; mb = 0; mf = 0; me = 0; mfc = 0; mei = 0; mdt = 0; mdb = 0;
      mrun = 0; mstart = 0;
    end else begin
      ev = blk_done && mrun;
      rp = ev && mr[0][9:8] == 2'b11 && mr[0][7];
      rl = wr_en && addr == 0 && mr[0][0] && !wdata[0];
      cp = rp || (mr[0][11] && (!mrun || ev));
      old_st = mr[3][3];
      if (cp) begin
        mt = {mr[4], mr[5]}; mb = {mr[6], mr[7]}; mf = {mr[8], mr[9]};
        me = mr[10]; mfc = mr[11]; mei = mr[12];
        mdt = mr[1][1:0]; mdb = (mr[0][13:12] == 2'b11);
      end
      mstart = 0;
      if (rl) mrun = 0;
      else if (!mrun) begin
        if (mr[0][7]) begin mrun = 1; mstart = 1; end
      end else if (rp) mstart = 1;
      else if (ev || !mr[0][7]) mrun = 0;
      if (wr_en && addr <= 12) begin
        if (addr == 3) mr[3] = {wdata[15:4], old_st && !wdata[3], wdata[2:0]};
        else mr[addr] = wdata;
      end
      if (ev) mr[3][3] = 1;
      if (cp && !(wr_en && addr == 0 && wdata[11])) mr[0][11] = 0;
      if ((ev && !rp) || rl) mr[0][7] = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R4", "running", running, mrun);
      chk("R6", "start", start, mstart);
      chk("R8", "irq", irq, mr[3][3] & mr[3][1]);
      chk("R3", "act_top", act_top, mt);
      chk("R3", "act_bot", act_bot, mb);
      chk("R3", "act_fidx", act_fidx, mf);
      chk("R3", "act_counts", {act_ecnt, act_fcnt}, {me, mfc});
      chk("R3", "act_eidx", act_eidx, mei);
      chk("R11", "act_type", {act_dtype, act_dbl_idx}, {mdt, mdb});
      chk("R11", "port", {src_port, ext_req_en}, {mr[3][7:6], mr[3][8]});
      chk("R2", "rdata", rdata, addr <= 12 ? mr[addr] : 16'h0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic blk = 0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; blk_done = blk;
    @(negedge clk); wr_en = 0; blk_done = 0;
  endtask
  task automatic pulse;
    @(negedge clk); blk_done = 1;
    @(negedge clk); blk_done = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(3); rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1", "chan ctl reset", v, 16'h5440);
    rd(1, v); chk("R1", "param reset", v, 16'h9102);
    rd(2, v); chk("R1", "lch reset", v, 16'h0004);
    rd(3, v); chk("R1", "disp ctl reset", v, 16'h0000);
    chk("R1", "run/irq/gate reset", {running, irq, ext_req_en}, 3'b000);
    // R2 halves
    wr(4, 16'h1234); wr(5, 16'h5678); wr(6, 16'h00AB); wr(7, 16'hCDEF);
    wr(8, 16'hFFFF); wr(9, 16'hFFFE); wr(10, 16'd320); wr(11, 16'd240); wr(12, 16'd1);
    rd(4, v); chk("R2", "top upper", v, 16'h1234);
    rd(9, v); chk("R2", "fidx lower", v, 16'hFFFE);
    rd(14, v); chk("R2", "unmapped", v, 16'h0);
    // R3 idle copy
    wr(0, 16'h5C40); cyc(2);
    chk("R3", "idle copy top", act_top, 32'h12345678);
    chk("R3", "idle copy fidx", act_fidx, 32'hFFFFFFFE);
    rd(0, v); chk("R3", "end-prog cleared", v[11], 1'b0);
    chk("R11", "dtype from param", act_dtype, 2'd2);
    // R4 single block start
    wr(0, 16'h54C0); cyc(2);
    chk("R4", "running after enable", running, 1'b1);
    // R5/R7 single stop and status
    pulse(); cyc(1);
    chk("R5", "stopped", running, 1'b0);
    rd(0, v); chk("R5", "enable cleared", v[7], 1'b0);
    rd(3, v); chk("R7", "status set", v[3], 1'b1);
    chk("R8", "irq masked", irq, 1'b0);
    wr(3, 16'h0002); cyc(1);
    chk("R8", "irq enabled", irq, 1'b1);
    wr(3, 16'h000A); cyc(1);
    rd(3, v); chk("R7", "w1c clears", v[3], 1'b0);
    chk("R8", "irq low after ack", irq, 1'b0);
    // R7 idle completion ignored
    pulse(); cyc(1);
    rd(3, v); chk("R7", "idle pulse ignored", v[3], 1'b0);
    // R6 repeat mode, R3 deferred copy
    wr(0, 16'h7380); cyc(2);
    chk("R6", "repeat running", running, 1'b1);
    wr(4, 16'h0BAD); wr(0, 16'h7B80); cyc(3);
    chk("R3", "copy deferred while running", act_top, 32'h12345678);
    pulse(); cyc(1);
    chk("R6", "reload on completion", act_top, 32'h0BAD5678);
    chk("R6", "still running", running, 1'b1);
    chk("R11", "double index", act_dbl_idx, 1'b1);
    // R7 collision: completion with ack in same cycle
    wr(3, 16'h000A, 1'b1); cyc(1);
    rd(3, v); chk("R7", "set wins over ack", v[3], 1'b1);
    // R3/R6 collision: completion with end-prog write
    wr(5, 16'h9999); wr(0, 16'h7B80, 1'b1); cyc(2);
    chk("R6", "reload with pending program", act_top, 32'h0BAD9999);
    // R9 software stop
    wr(0, 16'h7300); cyc(2);
    chk("R9", "stopped by clear", running, 1'b0);
    // R10 release
    wr(0, 16'h7381); cyc(2);
    chk("R10", "running before release", running, 1'b1);
    wr(0, 16'h7380); cyc(1);
    chk("R10", "idle after release", running, 1'b0);
    rd(0, v); chk("R10", "enable cleared", v[7], 1'b0);
    // R11 port/gate
    wr(3, 16'h01C8); cyc(1);
    chk("R11", "source port", src_port, 2'd3);
    chk("R11", "external gate", ext_req_en, 1'b1);
    cyc(3);
    done = 1;
    summary();
    $finish;
  end
endmodule